// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs nested hardware loops for a small processor sequencer. It holds three pieces of loop state: the end address of the current loop body, the count of iterations left, and a flag that marks a loop as active. A loop command first saves the previous loop context onto an external system stack. That stack has two 16-bit fields per entry, and the block uses two entries per loop. The block then loads the new end address and count. Because each level of nesting is kept on the shared stack, nested loops need no extra registers inside the block.

On each instruction fetch the block compares the fetch address with the stored end address, and only while a loop is active. On a match with more iterations left, it redirects the sequencer in the same cycle to the start address held in the top stack entry, and it decrements the count. On the last iteration it lets the program counter run on and pulls two entries to restore the outer context. An early-exit command performs the same unstacking. A loop command with a zero count skips the body entirely, with no stack traffic. The current end address, count and flag are always visible on output ports.

The stack storage is outside the block. It presents its top entry on the read ports at all times. The block's `ready` output tells the sequencer when a new command may be issued.

Top module: `zloop_ctrl`

## Requirements
- R1: During and after reset, `la` and `lc` are zero, `lf` is 0, `ready` is 1, and neither `stk_push` nor `stk_pull` is asserted.
- R2: A loop command with a nonzero count, issued while `ready`, pushes two entries on consecutive cycles. The first entry is {high = old `la`, low = old `lc`}. The second is {high = `do_start`, low = `sr_in` with bit 15 replaced by the current `lf`}. `ready` is low during the second push. In the following cycle `la` = `do_end`, `lc` = `do_count` and `lf` = 1.
- R3: A fetch with `fetch_valid`, `lf` = 1, `fetch_addr` = `la` and `lc` != 1 raises `pc_redirect` in the same cycle, with `pc_target` equal to the high field of the top stack entry. `lc` drops by one in the next cycle, and there is no stack operation.
- R4: A fetch at `la` with `lf` = 1 and `lc` = 1 gives no redirect and pulls on two consecutive cycles. The first pull restores `lf` from bit 15 of the low field. The second restores `la` from the high field and `lc` from the low field.
- R5: A loop command with `do_count` = 0 raises `pc_redirect` in the same cycle with `pc_target` = `do_end` + 1. It performs no stack operation and leaves `la`, `lc` and `lf` unchanged.
- R6: An early-exit command while `lf` = 1 performs the same two-pull unstacking as R4, with no redirect. While `lf` = 0 the command has no effect.
- R7: While `lf` = 0, a fetch whose address equals `la` causes no redirect, no stack operation and no change of `lc`.
- R8: A fetch whose address differs from `la` causes no redirect and leaves `lc` unchanged.
- R9: When an inner loop ends, the outer loop's `la` and `lc` are restored with `lf` = 1, and its fetches again branch to the outer start address.
- R10: In one cycle, a loop command takes priority over an early exit, and an early exit takes priority over a fetch match. All commands are ignored while `ready` is low.
- R11: `stk_push` and `stk_pull` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_req | input | 1 | Start-loop command |
| do_start | input | 16 | Address of the first body instruction |
| do_end | input | 16 | Address of the last body instruction |
| do_count | input | 16 | Iteration count |
| enddo_req | input | 1 | Early-exit command |
| fetch_valid | input | 1 | A fetch takes place this cycle |
| fetch_addr | input | 16 | Address being fetched |
| sr_in | input | 16 | Status word saved with the loop context |
| stk_rd_hi | input | 16 | High field of the top stack entry |
| stk_rd_lo | input | 16 | Low field of the top stack entry |
| stk_push | output | 1 | Push strobe |
| stk_pull | output | 1 | Pull strobe |
| stk_wr_hi | output | 16 | High field to push |
| stk_wr_lo | output | 16 | Low field to push |
| pc_redirect | output | 1 | Take `pc_target` as the next fetch address |
| pc_target | output | 16 | Redirect address |
| ready | output | 1 | Block can accept a command |
| la | output | 16 | Current loop end address |
| lc | output | 16 | Remaining iteration count |
| lf | output | 1 | Loop active flag |

## Verification
The hardest case to reach from the ports is an inner loop ending while an outer loop is still active. Here the loop flag must come back as 1 from the saved status word, and the next branch must read the outer start address that is now on top of the stack. The bench gets there by opening an outer loop, opening an inner loop, stepping the inner loop once and exiting it early. It then checks the restored state and the next branch target. A final cycle drives the loop, exit and fetch-match commands together to check the priority order. A further command is driven while the block is unstacking, to check that busy cycles ignore it.

// File: rtl/zloop_pkg.sv
package zloop_pkg;

   // Sequencer state: the idle state issues the first stack operation of a
   // sequence, the tail states issue the second one.
   typedef enum logic [1:0] {
      ZL_IDLE      = 2'd0,
      ZL_PUSH_TAIL = 2'd1,
      ZL_PULL_TAIL = 2'd2
   } zl_state_e;

   // Update applied to the loop context registers in a cycle.
   typedef enum logic [2:0] {
      CTX_HOLD     = 3'd0,
      CTX_CAPTURE  = 3'd1,
      CTX_LOAD     = 3'd2,
      CTX_DEC      = 3'd3,
      CTX_POP_FLAG = 3'd4,
      CTX_POP_REGS = 3'd5
   } ctx_op_e;

endpackage

// File: rtl/zloop_zext.sv
module zloop_zext #(
   parameter int IW = 16,
   parameter int OW = 16
) (
   input  logic [IW-1:0] din,
   output logic [OW-1:0] dout
);
   localparam int PAD = OW - IW;

   if (IW > OW) begin : g_bad_width
      $error("zloop_zext: input wider than output");
   end
   if (PAD == 0) begin : g_pass
      assign dout = din;
   end else begin : g_pad
      assign dout = {{PAD{1'b0}}, din};
   end
endmodule

// File: rtl/zloop_end_cmp.sv
module zloop_end_cmp #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   input  logic [AW-1:0] la,
   input  logic [CW-1:0] lc,
   input  logic          lf,
   output logic          hit,
   output logic          last
);
   localparam logic [CW-1:0] ONE = CW'(1);

   // The comparison only counts while a loop is active.
   assign hit  = fetch_valid && lf && (fetch_addr == la);
   assign last = (lc == ONE);
endmodule

// File: rtl/zloop_seq.sv
module zloop_seq
   import zloop_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    do_req,
   input  logic    count_zero,
   input  logic    enddo_req,
   input  logic    lf,
   input  logic    hit,
   input  logic    last,
   output logic    ready,
   output logic    push,
   output logic    pull,
   output logic    push_tail,
   output logic    skip,
   output logic    loop_back,
   output ctx_op_e op
);
   zl_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ZL_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d   = state_q;
      push      = 1'b0;
      pull      = 1'b0;
      push_tail = 1'b0;
      skip      = 1'b0;
      loop_back = 1'b0;
      op        = CTX_HOLD;
      ready     = (state_q == ZL_IDLE);
      case (state_q)
         ZL_IDLE: begin
            if (do_req) begin
               if (count_zero) begin
                  skip = 1'b1;
               end else begin
                  push    = 1'b1;
                  op      = CTX_CAPTURE;
                  state_d = ZL_PUSH_TAIL;
               end
            end else if (enddo_req && lf) begin
               pull    = 1'b1;
               op      = CTX_POP_FLAG;
               state_d = ZL_PULL_TAIL;
            end else if (hit) begin
               if (!last) begin
                  loop_back = 1'b1;
                  op        = CTX_DEC;
               end else begin
                  pull    = 1'b1;
                  op      = CTX_POP_FLAG;
                  state_d = ZL_PULL_TAIL;
               end
            end
         end
         ZL_PUSH_TAIL: begin
            push      = 1'b1;
            push_tail = 1'b1;
            op        = CTX_LOAD;
            state_d   = ZL_IDLE;
         end
         ZL_PULL_TAIL: begin
            pull    = 1'b1;
            op      = CTX_POP_REGS;
            state_d = ZL_IDLE;
         end
         default: state_d = ZL_IDLE;
      endcase
   end
endmodule

// File: rtl/zloop_ctx.sv
module zloop_ctx
   import zloop_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ctx_op_e       op,
   input  logic [AW-1:0] new_start,
   input  logic [AW-1:0] new_end,
   input  logic [CW-1:0] new_count,
   input  logic          pop_flag,
   input  logic [AW-1:0] pop_la,
   input  logic [CW-1:0] pop_lc,
   output logic [AW-1:0] la,
   output logic [CW-1:0] lc,
   output logic          lf,
   output logic [AW-1:0] pend_start
);
   logic [AW-1:0] pend_end;
   logic [CW-1:0] pend_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         la         <= '0;
         lc         <= '0;
         lf         <= 1'b0;
         pend_start <= '0;
         pend_end   <= '0;
         pend_count <= '0;
      end else begin
         case (op)
            CTX_CAPTURE: begin
               pend_start <= new_start;
               pend_end   <= new_end;
               pend_count <= new_count;
            end
            CTX_LOAD: begin
               la <= pend_end;
               lc <= pend_count;
               lf <= 1'b1;
            end
            CTX_DEC:      lc <= lc - CW'(1);
            CTX_POP_FLAG: lf <= pop_flag;
            CTX_POP_REGS: begin
               la <= pop_la;
               lc <= pop_lc;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
   import zloop_pkg::*;
#(
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int SW     = 16,
   parameter int STK_W  = 16,
   parameter int LF_BIT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_req,
   input  logic [AW-1:0]    do_start,
   input  logic [AW-1:0]    do_end,
   input  logic [CW-1:0]    do_count,
   input  logic             enddo_req,
   input  logic             fetch_valid,
   input  logic [AW-1:0]    fetch_addr,
   input  logic [SW-1:0]    sr_in,
   input  logic [STK_W-1:0] stk_rd_hi,
   input  logic [STK_W-1:0] stk_rd_lo,
   output logic             stk_push,
   output logic             stk_pull,
   output logic [STK_W-1:0] stk_wr_hi,
   output logic [STK_W-1:0] stk_wr_lo,
   output logic             pc_redirect,
   output logic [AW-1:0]    pc_target,
   output logic             ready,
   output logic [AW-1:0]    la,
   output logic [CW-1:0]    lc,
   output logic             lf
);
   if (AW > STK_W) begin : g_chk_aw
      $error("zloop_ctrl: address wider than a stack field");
   end
   if (CW > STK_W) begin : g_chk_cw
      $error("zloop_ctrl: count wider than a stack field");
   end
   if (SW > STK_W) begin : g_chk_sw
      $error("zloop_ctrl: status wider than a stack field");
   end
   if (LF_BIT >= SW) begin : g_chk_lf
      $error("zloop_ctrl: loop flag bit outside the status word");
   end

   logic          hit, last, push_tail, skip, loop_back;
   ctx_op_e       op;
   logic [AW-1:0] pend_start;
   logic [SW-1:0] sr_tagged;
   logic [STK_W-1:0] la_x, lc_x, start_x, sr_x;

   zloop_end_cmp #(.AW(AW), .CW(CW)) u_cmp (
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .la          (la),
      .lc          (lc),
      .lf          (lf),
      .hit         (hit),
      .last        (last)
   );

   zloop_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .do_req     (do_req),
      .count_zero (do_count == '0),
      .enddo_req  (enddo_req),
      .lf         (lf),
      .hit        (hit),
      .last       (last),
      .ready      (ready),
      .push       (stk_push),
      .pull       (stk_pull),
      .push_tail  (push_tail),
      .skip       (skip),
      .loop_back  (loop_back),
      .op         (op)
   );

   zloop_ctx #(.AW(AW), .CW(CW)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .new_start  (do_start),
      .new_end    (do_end),
      .new_count  (do_count),
      .pop_flag   (stk_rd_lo[LF_BIT]),
      .pop_la     (stk_rd_hi[AW-1:0]),
      .pop_lc     (stk_rd_lo[CW-1:0]),
      .la         (la),
      .lc         (lc),
      .lf         (lf),
      .pend_start (pend_start)
   );

   // Saved status carries the live loop flag in its fixed bit.
   always_comb begin
      sr_tagged         = sr_in;
      sr_tagged[LF_BIT] = lf;
   end

   zloop_zext #(.IW(AW), .OW(STK_W)) u_x_la    (.din(la),         .dout(la_x));
   zloop_zext #(.IW(CW), .OW(STK_W)) u_x_lc    (.din(lc),         .dout(lc_x));
   zloop_zext #(.IW(AW), .OW(STK_W)) u_x_start (.din(pend_start), .dout(start_x));
   zloop_zext #(.IW(SW), .OW(STK_W)) u_x_sr    (.din(sr_tagged),  .dout(sr_x));

   assign stk_wr_hi   = push_tail ? start_x : la_x;
   assign stk_wr_lo   = push_tail ? sr_x    : lc_x;
   assign pc_redirect = skip | loop_back;
   assign pc_target   = skip ? (do_end + AW'(1)) : stk_rd_hi[AW-1:0];
endmodule

// File: rtl/zloop_ctrl_chk.sv
module zloop_ctrl_chk #(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int STK_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             do_req,
   input logic [AW-1:0]    do_end,
   input logic [CW-1:0]    do_count,
   input logic             enddo_req,
   input logic             fetch_valid,
   input logic [AW-1:0]    fetch_addr,
   input logic [STK_W-1:0] stk_rd_hi,
   input logic             stk_push,
   input logic             stk_pull,
   input logic             pc_redirect,
   input logic [AW-1:0]    pc_target,
   input logic             ready,
   input logic [AW-1:0]    la,
   input logic [CW-1:0]    lc,
   input logic             lf
);
   logic match_go;
   assign match_go = ready && !do_req && !enddo_req && fetch_valid && lf
                     && (fetch_addr == la);

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (la == '0 && lc == '0 && !lf && ready && !stk_push && !stk_pull));

   a_r2_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && do_req && do_count != '0) |-> stk_push ##1 (stk_push && !ready));

   a_r2_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && stk_push) |=> (ready && lf));

   a_r3_branch_back: assert property (@(posedge clk) disable iff (!rst_n)
      (match_go && lc != CW'(1)) |-> (pc_redirect && pc_target == stk_rd_hi[AW-1:0]
                                       && !stk_push && !stk_pull));

   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (match_go && lc != CW'(1)) |=> (lc == $past(lc) - CW'(1)));

   a_r4_exit_pulls: assert property (@(posedge clk) disable iff (!rst_n)
      (match_go && lc == CW'(1)) |-> (stk_pull && !pc_redirect) ##1 (stk_pull && !ready));

   a_r5_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && do_req && do_count == '0) |-> (pc_redirect && pc_target == do_end + AW'(1)
                                               && !stk_push && !stk_pull));

   a_r5_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && do_req && do_count == '0) |=> (la == $past(la) && lc == $past(lc)
                                               && lf == $past(lf)));

   a_r6_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !do_req && enddo_req && lf) |-> (stk_pull && !pc_redirect));

   a_r7_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !do_req && !lf) |-> (!pc_redirect && !stk_push && !stk_pull));

   a_r10_busy_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !pc_redirect);

   a_r11_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      !(stk_push && stk_pull));
endmodule

bind zloop_ctrl zloop_ctrl_chk #(.AW(AW), .CW(CW), .STK_W(STK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .do_req      (do_req),
   .do_end      (do_end),
   .do_count    (do_count),
   .enddo_req   (enddo_req),
   .fetch_valid (fetch_valid),
   .fetch_addr  (fetch_addr),
   .stk_rd_hi   (stk_rd_hi),
   .stk_push    (stk_push),
   .stk_pull    (stk_pull),
   .pc_redirect (pc_redirect),
   .pc_target   (pc_target),
   .ready       (ready),
   .la          (la),
   .lc          (lc),
   .lf          (lf)
);

// File: tb/zloop_ctrl_tb.sv
module zloop_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        do_req = 1'b0, enddo_req = 1'b0, fetch_valid = 1'b0;
   logic [15:0] do_start = '0, do_end = '0, do_count = '0, fetch_addr = '0, sr_in = '0;
   logic [15:0] stk_rd_hi, stk_rd_lo, stk_wr_hi, stk_wr_lo, pc_target, la, lc;
   logic        stk_push, stk_pull, pc_redirect, ready, lf;

   int nchk = 0;
   int nfail = 0;
   bit overlap_seen = 1'b0;

   // External stack model
   logic [15:0] mem_hi [0:15];
   logic [15:0] mem_lo [0:15];
   int sp = 0;
   assign stk_rd_hi = (sp == 0) ? 16'h0 : mem_hi[sp-1];
   assign stk_rd_lo = (sp == 0) ? 16'h0 : mem_lo[sp-1];
   always @(posedge clk) begin
      if (stk_push) begin
         mem_hi[sp] <= stk_wr_hi;
         mem_lo[sp] <= stk_wr_lo;
         sp <= sp + 1;
      end else if (stk_pull) begin
         sp <= sp - 1;
      end
   end

   always #4 clk = ~clk;

   zloop_ctrl u_dut (.*);

   always @(negedge clk) if (rst_n && stk_push && stk_pull) overlap_seen = 1'b1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      do_req = 0; enddo_req = 0; fetch_valid = 0;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk("R1 la", la, 0);
      chk("R1 lc", lc, 0);
      chk("R1 lf", lf, 0);
      chk("R1 ready", ready, 1);
      chk("R1 push/pull", {stk_push, stk_pull}, 0);
   endtask

   task automatic t_single_loop();
      sr_in = 16'h0123;
      do_req = 1; do_start = 16'h0100; do_end = 16'h0104; do_count = 16'd3;
      #1;
      chk("R2 first push", {stk_push, ready, pc_redirect}, 3'b110);
      chk("R2 first entry", {stk_wr_hi, stk_wr_lo}, 32'h0);
      step(); idle_inputs(); #1;
      chk("R2 second push busy", {stk_push, ready}, 2'b10);
      chk("R2 second entry", {stk_wr_hi, stk_wr_lo}, 32'h0100_0123);
      step();
      chk("R2 loaded", {la, lc}, 32'h0104_0003);
      chk("R2 lf set", {lf, ready}, 2'b11);
      chk("R2 depth", sp, 2);
      fetch_valid = 1; fetch_addr = 16'h0102; #1;
      chk("R8 no redirect", {pc_redirect, stk_push, stk_pull}, 0);
      step(); fetch_addr = 16'h0104; #1;
      chk("R8 lc kept", lc, 3);
      chk("R3 redirect", {pc_redirect, pc_target}, {1'b1, 16'h0100});
      chk("R3 no stack op", {stk_push, stk_pull}, 0);
      step(); #0;
      chk("R3 decrement", lc, 2);
      step();
      chk("R3 decrement again", lc, 1);
      #0;
      chk("R4 no redirect, pull", {pc_redirect, stk_pull}, 2'b01);
      step(); idle_inputs(); #1;
      chk("R4 second pull busy", {stk_pull, ready}, 2'b10);
      chk("R4 flag restored first", {lf, la}, {1'b0, 16'h0104});
      step();
      chk("R4 regs restored", {la, lc}, 32'h0);
      chk("R4 depth", sp, 0);
   endtask

   task automatic t_skip();
      do_req = 1; do_end = 16'h0200; do_count = 16'd0; #1;
      chk("R5 skip redirect", {pc_redirect, pc_target}, {1'b1, 16'h0201});
      chk("R5 no stack op", {stk_push, stk_pull}, 0);
      step(); idle_inputs(); #1;
      chk("R5 regs unchanged", {lf, la, lc}, 33'h0);
      chk("R5 ready", ready, 1);
   endtask

   task automatic t_inactive();
      fetch_valid = 1; fetch_addr = 16'h0000; #1;
      chk("R7 match ignored", {pc_redirect, stk_push, stk_pull}, 0);
      step(); idle_inputs(); enddo_req = 1; #1;
      chk("R7 lc unchanged", lc, 0);
      chk("R6 exit ignored when inactive", {stk_pull, pc_redirect}, 0);
      step(); idle_inputs(); #1;
      chk("R6 state unchanged", {lf, la, lc, ready}, {33'h0, 1'b1});
   endtask

   task automatic t_nested();
      sr_in = 16'h0000;
      do_req = 1; do_start = 16'h0010; do_end = 16'h0030; do_count = 16'd2;
      step(); idle_inputs(); step();
      chk("R9 outer loaded", {la, lc}, 32'h0030_0002);
      sr_in = 16'h0005;
      do_req = 1; do_start = 16'h0020; do_end = 16'h0025; do_count = 16'd5; #1;
      chk("R9 outer context pushed", {stk_wr_hi, stk_wr_lo}, 32'h0030_0002);
      step(); idle_inputs(); #1;
      chk("R2 flag saved in status", {stk_wr_hi, stk_wr_lo}, 32'h0020_8005);
      step();
      chk("R9 inner loaded", {la, lc, lf}, {32'h0025_0005, 1'b1});
      fetch_valid = 1; fetch_addr = 16'h0025; #1;
      chk("R3 inner branch", {pc_redirect, pc_target}, {1'b1, 16'h0020});
      step(); idle_inputs(); #1;
      chk("R3 inner count", lc, 4);
      enddo_req = 1; #1;
      chk("R6 early exit pulls", {stk_pull, pc_redirect}, 2'b10);
      step(); idle_inputs(); #1;
      chk("R6 second pull", {stk_pull, ready, lf}, 3'b101);
      step();
      chk("R9 outer restored", {la, lc, lf}, {32'h0030_0002, 1'b1});
      chk("R9 depth", sp, 2);
      fetch_valid = 1; fetch_addr = 16'h0030; #1;
      chk("R9 outer branch target", {pc_redirect, pc_target}, {1'b1, 16'h0010});
      step(); idle_inputs(); #1;
      chk("R9 outer count", lc, 1);
   endtask

   task automatic t_priority();
      do_req = 1; do_end = 16'h0040; do_count = 16'd0;
      enddo_req = 1; fetch_valid = 1; fetch_addr = 16'h0030; #1;
      chk("R10 loop cmd wins", {pc_redirect, pc_target, stk_pull, stk_push}, {1'b1, 16'h0041, 2'b00});
      step(); do_req = 0; #1;
      chk("R10 state kept", {la, lc, lf}, {32'h0030_0001, 1'b1});
      chk("R10 exit beats fetch", {stk_pull, pc_redirect}, 2'b10);
      step(); idle_inputs();
      do_req = 1; do_start = 16'h0050; do_end = 16'h0060; do_count = 16'd4; #1;
      chk("R10 busy ignores loop cmd", {ready, stk_push, stk_pull, pc_redirect}, 4'b0010);
      step(); idle_inputs(); #1;
      chk("R10 fully unwound", {la, lc, lf}, 33'h0);
      chk("R10 depth", sp, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1;
      step();
      t_single_loop();
      t_skip();
      t_inactive();
      t_nested();
      t_priority();
      step();
      chk("R11 push and pull never together", overlap_seen, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule